// File: doc/BRIEF.md
# Weighted Coin Flip Generator

The block draws one Bernoulli sample per enabled clock cycle. The chance of a 1 is given by an unsigned weight `w` of `WEIGHT_W` bits. A sample is 1 with probability exactly `w / 2^WEIGHT_W`. For example, with a 4-bit weight of 0111 the chance of a 1 is 7/16.

The fair random bits come from a private 128-bit xorshift generator with full period. The generator advances once for every sample. The low `WEIGHT_W` bits of the word it has just produced are compared with the weight. The sample is 1 when those bits are strictly smaller than the weight.

Each instance takes its own 128-bit seed. The seed is loaded while the block is held in reset, so copies placed side by side produce unrelated streams. An all-zero seed would lock the generator, so it is replaced by a fixed nonzero constant.

Top module: `weighted_coin`

## Requirements
- R1: While `rst_n` is low, `valid_o` and `sample_o` are 0. They stay 0 until the first enabled cycle after reset.
- R2: `valid_o` is 1 in the cycle after a clock edge at which `en_i` was high and the block was out of reset. It is 0 in the cycle after an edge at which `en_i` was low.
- R3: For each enabled edge, `sample_o` becomes 1 if and only if the low `WEIGHT_W` bits of the newly generated word are strictly below `weight_i`. This includes the boundary weights 1 and all-ones.
- R4: A weight of zero always gives a `sample_o` of 0.
- R5: With `en_i` low, the generator does not advance and `sample_o` holds its value. The stream resumes exactly where it stopped.
- R6: The seed is captured while the internal reset is active. `seed_i[31:0]` is word x, `[63:32]` is y, `[95:64]` is z and `[127:96]` is w.
- R7: An all-zero seed is replaced by 128'h9E3779B9_7F4A7C15_F39CC060_5CEDC834, using the same word order, and the generator state is never all-zero.
- R8: Each step computes t = x ^ (x << 11). The words then move down one place (x takes y, y takes z, z takes w). The new w is w ^ (w >> 19) ^ t ^ (t >> 8).
- R9: Two different seeds give different sample sequences for the same weights.
- R10: With weight 64 of 256, about a quarter of 4096 samples are 1, within ±128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low. It takes effect at once and is released through a synchroniser. |
| seed_i | input | 128 | Generator seed, captured during reset |
| weight_i | input | WEIGHT_W | Probability weight; P(1) = weight / 2^WEIGHT_W |
| en_i | input | 1 | Draw a sample at this edge |
| sample_o | output | 1 | Registered Bernoulli sample |
| valid_o | output | 1 | The sample was drawn at the previous edge |

## Verification
The bound checker watches several things on every cycle. It checks the valid timing against enable, and that a zero weight gives no ones. It checks that the state and the sample do not move while enable is low, and that the generator state never reaches all-zero. Only the bench scenarios can show three things. The first is that each sample follows the exact comparison of fresh generator bits with the weight, at the seed order and recurrence. The second is that the zero-seed substitute and distinct seeds give the expected streams. The third is that the long-run frequency tracks the weight.

// File: rtl/wcoin_pkg.sv
package wcoin_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int SEED_W  = WORD_W * NWORDS;

  // xorshift shift amounts
  localparam int SH_A = 11;
  localparam int SH_B = 19;
  localparam int SH_C = 8;

  typedef logic [WORD_W-1:0] word_t;

  // x occupies the least significant word
  typedef struct packed {
    word_t w;
    word_t z;
    word_t y;
    word_t x;
  } xs_state_t;

  localparam logic [SEED_W-1:0] SEED_FALLBACK =
    128'h9E3779B9_7F4A7C15_F39CC060_5CEDC834;
endpackage

// File: rtl/wcoin_rst_sync.sv
module wcoin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wcoin_seed_fix.sv
module wcoin_seed_fix
  import wcoin_pkg::*;
(
  input  logic [SEED_W-1:0] seed_raw,
  output xs_state_t         seed_ok
);
  always_comb begin
    if (seed_raw == '0) seed_ok = xs_state_t'(SEED_FALLBACK);
    else                seed_ok = xs_state_t'(seed_raw);
  end
endmodule

// File: rtl/wcoin_xorshift.sv
module wcoin_xorshift
  import wcoin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  xs_state_t load_val,
  input  logic      step,
  output xs_state_t state,
  output word_t     fresh_word
);
  xs_state_t state_q;
  xs_state_t state_d;
  xs_state_t stepped;
  word_t     tmix;

  // one generator step
  always_comb begin
    tmix         = state_q.x ^ (state_q.x << SH_A);
    stepped.x    = state_q.y;
    stepped.y    = state_q.z;
    stepped.z    = state_q.w;
    stepped.w    = state_q.w ^ (state_q.w >> SH_B) ^ tmix ^ (tmix >> SH_C);
  end

  always_comb begin
    state_d = state_q;
    if (load)      state_d = load_val;
    else if (step) state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= xs_state_t'(SEED_FALLBACK);
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign fresh_word = stepped.w;
endmodule

// File: rtl/wcoin_cmp.sv
module wcoin_cmp #(
  parameter int WEIGHT_W = 8
) (
  input  logic [WEIGHT_W-1:0] rnd,
  input  logic [WEIGHT_W-1:0] weight,
  output logic                below
);
  generate
    if (WEIGHT_W == 1) begin : g_bit
      assign below = weight[0] & ~rnd[0];
    end else begin : g_mag
      assign below = (rnd < weight);
    end
  endgenerate
endmodule

// File: rtl/weighted_coin.sv
module weighted_coin
  import wcoin_pkg::*;
#(
  parameter int WEIGHT_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEED_W-1:0]   seed_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  input  logic                en_i,
  output logic                sample_o,
  output logic                valid_o
);
  logic      rst_int_n;
  xs_state_t seed_ok;
  xs_state_t prng_state;
  word_t     fresh_word;
  logic      below;
  logic      draw;
  logic      sample_q, sample_d;
  logic      valid_q, valid_d;

  wcoin_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  wcoin_seed_fix u_seed (
    .seed_raw (seed_i),
    .seed_ok  (seed_ok)
  );

  assign draw = rst_int_n & en_i;

  wcoin_xorshift u_prng (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (~rst_int_n),
    .load_val   (seed_ok),
    .step       (draw),
    .state      (prng_state),
    .fresh_word (fresh_word)
  );

  wcoin_cmp #(.WEIGHT_W(WEIGHT_W)) u_cmp (
    .rnd    (fresh_word[WEIGHT_W-1:0]),
    .weight (weight_i),
    .below  (below)
  );

  always_comb begin
    sample_d = sample_q;
    valid_d  = 1'b0;
    if (!rst_int_n) begin
      sample_d = 1'b0;
    end else if (en_i) begin
      sample_d = below;
      valid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= sample_d;
      valid_q  <= valid_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/wcoin_chk.sv
module wcoin_chk #(
  parameter int WEIGHT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_int_n,
  input logic                en_i,
  input logic [WEIGHT_W-1:0] weight_i,
  input logic                sample_o,
  input logic                valid_o,
  input logic [127:0]        prng_state
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && !sample_o));

  assert_valid_follows_en_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    en_i |=> valid_o);

  assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> !valid_o);

  assert_zero_weight_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_i && weight_i == '0) |=> !sample_o);

  assert_hold_state_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> ($stable(prng_state) && $stable(sample_o)));

  assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prng_state != '0);
endmodule

bind weighted_coin wcoin_chk #(.WEIGHT_W(WEIGHT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_int_n  (rst_int_n),
  .en_i       (en_i),
  .weight_i   (weight_i),
  .sample_o   (sample_o),
  .valid_o    (valid_o),
  .prng_state (prng_state)
);

// File: tb/weighted_coin_tb.sv
module weighted_coin_tb;
  localparam int W = 8;
  localparam logic [127:0] FALLBACK = 128'h9E3779B9_7F4A7C15_F39CC060_5CEDC834;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] seed_i;
  logic [W-1:0] weight_i;
  logic         en_i;
  logic         sample_o, valid_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  bit [31:0] mx, my, mz, mw;
  bit exp_sample, exp_valid;
  bit in_rst;

  always #5 clk = ~clk;

  weighted_coin #(.WEIGHT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .weight_i(weight_i),
    .en_i(en_i), .sample_o(sample_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, expv, $time);
    end
  endtask

  task automatic load_model(input logic [127:0] s);
    logic [127:0] v;
    v  = (s == '0) ? FALLBACK : s;
    mx = v[31:0]; my = v[63:32]; mz = v[95:64]; mw = v[127:96];
  endtask

  // one clock: drive, update reference at the edge, compare at the next negedge
  task automatic tick(input logic en, input logic [W-1:0] wt);
    bit [31:0] t, nw;
    en_i = en; weight_i = wt;
    @(posedge clk);
    if (in_rst) begin
      exp_valid = 0; exp_sample = 0;
    end else if (en) begin
      t  = mx ^ (mx << 11);
      nw = mw ^ (mw >> 19) ^ t ^ (t >> 8);
      mx = my; my = mz; mz = mw; mw = nw;
      exp_sample = (nw[W-1:0] < wt);
      exp_valid  = 1;
    end else begin
      exp_valid = 0;
    end
    @(negedge clk);
    check(tag, valid_o, exp_valid, "valid");
    check(tag, sample_o, exp_sample, "sample");
  endtask

  task automatic do_reset(input logic [127:0] s);
    tag = "R1";
    seed_i = s; rst_n = 1'b0; in_rst = 1;
    exp_valid = 0; exp_sample = 0;
    #1;
    check("R1", valid_o, 1'b0, "valid in reset");
    check("R1", sample_o, 1'b0, "sample in reset");
    for (int i = 0; i < 3; i++) tick(1'b1, 8'hFF);
    rst_n = 1'b1;
    load_model(s);
    in_rst = 0;
    for (int i = 0; i < 4; i++) tick(1'b0, 8'h80);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pat_a, pat_b;
    int ones;
    rst_n = 1'b0; seed_i = '0; weight_i = '0; en_i = 1'b0; in_rst = 1;
    @(negedge clk);

    // R6 and R8: seed word order and recurrence, reflected in the stream
    do_reset(128'h01234567_89ABCDEF_DEADBEEF_00C0FFEE);
    tag = "R6";
    for (int i = 0; i < 64; i++) begin tick(1'b1, 8'h80); pat_a[i] = sample_o; end
    tag = "R8";
    for (int i = 0; i < 100; i++) tick(1'b1, 8'(i * 37));

    // R2 and R5: enable gaps keep the stream and the held sample
    tag = "R5";
    for (int i = 0; i < 120; i++) tick((i % 3) != 0, 8'(i * 11 + 5));
    tag = "R2";
    for (int i = 0; i < 40; i++) tick(i[0], 8'h55);

    // R4: zero weight
    tag = "R4"; ones = 0;
    for (int i = 0; i < 200; i++) begin tick(1'b1, 8'h00); ones += sample_o; end
    check("R4", ones != 0, 1'b0, "ones seen at weight zero");

    // R3: boundary weights
    tag = "R3";
    for (int i = 0; i < 100; i++) tick(1'b1, 8'hFF);
    for (int i = 0; i < 100; i++) tick(1'b1, 8'h01);

    // R1: reset during enabled operation
    tick(1'b1, 8'hFF);
    do_reset(128'h11111111_22222222_33333333_44444444);

    // R9: another seed, same weights
    tag = "R9";
    for (int i = 0; i < 64; i++) begin tick(1'b1, 8'h80); pat_b[i] = sample_o; end
    check("R9", pat_a != pat_b, 1'b1, "streams differ");

    // R7: zero seed uses the fallback constant
    do_reset('0);
    tag = "R7";
    for (int i = 0; i < 100; i++) tick(1'b1, 8'(255 - i));

    // R10: frequency at weight one quarter
    tag = "R10"; ones = 0;
    for (int i = 0; i < 4096; i++) begin tick(1'b1, 8'd64); ones += sample_o; end
    checks++;
    if (ones < 896 || ones > 1152) begin
      errors++;
      $display("FAIL R10 ones actual=%0d expected=1024+-128", ones);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule